// File: doc/BRIEF.md
# Virtual CPU Interrupt Interface

This block is the register interface that a guest processor sees for its virtual interrupts. A hypervisor loads a small bank of list entries through a dedicated side port. Each entry carries a virtual interrupt ID, a requesting-CPU tag, a 5-bit priority, a 2-bit state and a hardware-link bit. The guest reads an acknowledge register to take the most urgent pending entry, which then becomes active. It writes an end-of-interrupt register to retire an entry, matching on both the ID and the CPU tag.

A level virtual-IRQ output tells the guest that work is waiting. An error output flags any pending entry that carries the hardware-link bit. Such entries are not supported: they are never acknowledged.

The guest bus is a simple 32-bit request port with a one-cycle registered read response. Accesses are always accepted.

Top module: `vcpu_irq_if`

## Requirements
- R1: A read request (req_i=1, we_i=0) gives rvalid_o=1 with rdata_o on the following cycle, for exactly one cycle. A write request gives no rvalid_o.
- R2: A read of the acknowledge register (offset 0x00C) returns the selected entry as {19'b0, cpu[2:0], vid[9:0]}. That entry's state then becomes active (2), whether it was pending (1) or pending-and-active (3).
- R3: If no eligible entry is pending, or control bit 0 is clear, an acknowledge read returns 1023 and leaves every entry unchanged.
- R4: A write to the end-of-interrupt register (offset 0x010) sets to invalid (0) the lowest-index non-invalid entry whose vid equals wdata[9:0] and whose cpu equals wdata[12:10]. A write that matches no entry changes nothing.
- R5: The acknowledge register selects the pending entry with the numerically lowest priority field. When priorities are equal, the lowest entry index wins.
- R6: virq_o rises one cycle after an eligible entry is pending while control bit 0 is set. It falls one cycle after no eligible entry is pending. It stays high while entries remain pending, even after the enable bit is cleared.
- R7: A write to control (offset 0x000) stores all 32 bits. A write to the priority mask (offset 0x004) stores wdata[7:0]. Both read back as stored, and the mask reads with its upper bits zero.
- R8: A read of any offset other than 0x000, 0x004 or 0x00C returns 0, including a read of the end-of-interrupt register. A write to any offset other than 0x000, 0x004 or 0x010 changes nothing.
- R9: An entry with bit 31 (hardware link) set is never selected and never raises virq_o. err_o is high one cycle after any such entry is pending.
- R10: List entry layout: vid [9:0], cpu [12:10], priority [27:23], state [29:28] (0 invalid, 1 pending, 2 active, 3 pending-and-active), hardware link [31]. A hypervisor write (lr_we_i) replaces the whole entry lr_idx_i and takes precedence over a guest update to the same entry in that cycle. lr_rdata_o shows entry lr_ridx_i with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Guest register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (12) | Register byte offset |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| lr_we_i | input | 1 | Hypervisor list entry write strobe |
| lr_idx_i | input | IW (2) | Entry to write |
| lr_wdata_i | input | 32 | Entry write value |
| lr_ridx_i | input | IW (2) | Entry to observe |
| lr_rdata_o | output | 32 | Current value of entry lr_ridx_i |
| virq_o | output | 1 | Virtual IRQ level |
| err_o | output | 1 | A pending entry has the hardware-link bit set |

## Verification
A corrupted entry state is visible at the ports at once, because lr_rdata_o is combinational. It also shows up at the next acknowledge read, either as the wrong ID or as a spurious 1023 where a real ID was due. A broken selection order is caught by acknowledging entries that tie or differ in priority, and by checking the exact sequence of returned IDs. Flaws in the IRQ flag show on virq_o one cycle after the entry change that caused them. The hold case, where the enable bit is cleared while work is still pending, is exercised on its own.

// File: rtl/vcpu_irq_pkg.sv
package vcpu_irq_pkg;

  typedef enum logic [1:0] {
    LR_INVALID  = 2'd0,
    LR_PEND     = 2'd1,
    LR_ACT      = 2'd2,
    LR_PEND_ACT = 2'd3
  } lr_state_e;

  typedef struct packed {
    logic       hw;
    logic       rsvd_hi;
    lr_state_e  state;
    logic [4:0] prio;
    logic [9:0] rsvd_mid;
    logic [2:0] cpu;
    logic [9:0] vid;
  } lr_t;

  localparam int unsigned OFF_CTL = 'h000;
  localparam int unsigned OFF_PMR = 'h004;
  localparam int unsigned OFF_ACK = 'h00C;
  localparam int unsigned OFF_EOI = 'h010;

  localparam logic [9:0] SPURIOUS_ID = 10'd1023;

  function automatic logic is_pending(lr_state_e s);
    return (s == LR_PEND) || (s == LR_PEND_ACT);
  endfunction

endpackage

// File: rtl/vcpu_lr_bank.sv
module vcpu_lr_bank
  import vcpu_irq_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  localparam int unsigned IW = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hv_we_i,
  input  logic [IW-1:0] hv_idx_i,
  input  lr_t           hv_wdata_i,
  input  logic          ack_i,
  input  logic [IW-1:0] ack_idx_i,
  input  logic          eoi_i,
  input  logic [IW-1:0] eoi_idx_i,
  output lr_t           lr_o [NUM_LR]
);

  for (genvar i = 0; i < NUM_LR; i++) begin : g_lr
    lr_t lr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lr_q <= '0;
      end else if (hv_we_i && hv_idx_i == IW'(i)) begin
        lr_q <= hv_wdata_i;
      end else if (ack_i && ack_idx_i == IW'(i)) begin
        lr_q.state <= LR_ACT;
      end else if (eoi_i && eoi_idx_i == IW'(i)) begin
        lr_q.state <= LR_INVALID;
      end
    end
    assign lr_o[i] = lr_q;
  end

endmodule

// File: rtl/vcpu_pend_sel.sv
module vcpu_pend_sel
  import vcpu_irq_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  localparam int unsigned IW = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  lr_t               lr_i [NUM_LR],
  output logic [NUM_LR-1:0] elig_o,
  output logic              hw_pend_o,
  output logic [NUM_LR-1:0] grant_o,
  output logic [IW-1:0]     idx_o,
  output logic              found_o
);

  logic [NUM_LR-1:0] hw_vec;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_elig
    assign elig_o[i] = is_pending(lr_i[i].state) && !lr_i[i].hw;
    assign hw_vec[i] = is_pending(lr_i[i].state) && lr_i[i].hw;
  end

  assign hw_pend_o = |hw_vec;

  // Strict less-than keeps the lower index on equal priority.
  logic [4:0] best_prio;
  always_comb begin
    found_o   = 1'b0;
    idx_o     = '0;
    best_prio = '1;
    for (int i = 0; i < NUM_LR; i++) begin
      if (elig_o[i] && (!found_o || lr_i[i].prio < best_prio)) begin
        found_o   = 1'b1;
        idx_o     = IW'(i);
        best_prio = lr_i[i].prio;
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (found_o) grant_o[idx_o] = 1'b1;
  end

endmodule

// File: rtl/vcpu_eoi_match.sv
module vcpu_eoi_match
  import vcpu_irq_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  localparam int unsigned IW = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  lr_t           lr_i [NUM_LR],
  input  logic [9:0]    vid_i,
  input  logic [2:0]    cpu_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);

  logic [NUM_LR-1:0] match;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_match
    assign match[i] = (lr_i[i].state != LR_INVALID) &&
                      (lr_i[i].vid == vid_i) && (lr_i[i].cpu == cpu_i);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_LR - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end

endmodule

// File: rtl/vcpu_reg_if.sv
module vcpu_reg_if
  import vcpu_irq_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          sel_found_i,
  input  lr_t           sel_lr_i,
  output logic          ack_fire_o,
  output logic          eoi_fire_o,
  output logic          ctl_en_o,
  output logic          rvalid_o,
  output logic [31:0]   rdata_o
);

  logic        hit_ctl, hit_pmr, hit_ack, hit_eoi;
  logic        rd, wr;
  logic [31:0] ctl_q;
  logic [7:0]  pmr_q;
  logic [31:0] rd_mux;

  assign hit_ctl = addr_i == AW'(OFF_CTL);
  assign hit_pmr = addr_i == AW'(OFF_PMR);
  assign hit_ack = addr_i == AW'(OFF_ACK);
  assign hit_eoi = addr_i == AW'(OFF_EOI);
  assign rd      = req_i && !we_i;
  assign wr      = req_i && we_i;

  assign ctl_en_o   = ctl_q[0];
  assign ack_fire_o = rd && hit_ack && sel_found_i && ctl_q[0];
  assign eoi_fire_o = wr && hit_eoi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      pmr_q <= '0;
    end else if (wr) begin
      if (hit_ctl) ctl_q <= wdata_i;
      if (hit_pmr) pmr_q <= wdata_i[7:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctl) begin
      rd_mux = ctl_q;
    end else if (hit_pmr) begin
      rd_mux = {24'b0, pmr_q};
    end else if (hit_ack) begin
      rd_mux = (sel_found_i && ctl_q[0]) ? {19'b0, sel_lr_i.cpu, sel_lr_i.vid}
                                         : {22'b0, SPURIOUS_ID};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

endmodule

// File: rtl/vcpu_irq_if.sv
module vcpu_irq_if
  import vcpu_irq_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  parameter int unsigned AW     = 12,
  localparam int unsigned IW    = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic          rvalid_o,
  output logic [31:0]   rdata_o,
  input  logic          lr_we_i,
  input  logic [IW-1:0] lr_idx_i,
  input  logic [31:0]   lr_wdata_i,
  input  logic [IW-1:0] lr_ridx_i,
  output logic [31:0]   lr_rdata_o,
  output logic          virq_o,
  output logic          err_o
);

  lr_t               lr [NUM_LR];
  logic [NUM_LR-1:0] elig;
  logic [NUM_LR-1:0] grant;
  logic [IW-1:0]     sel_idx, eoi_idx;
  logic              sel_found, hw_pend, eoi_hit;
  logic              ack_fire, eoi_fire, ctl_en, any_pend;
  lr_t               sel_lr;

  vcpu_lr_bank #(.NUM_LR(NUM_LR)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hv_we_i    (lr_we_i),
    .hv_idx_i   (lr_idx_i),
    .hv_wdata_i (lr_t'(lr_wdata_i)),
    .ack_i      (ack_fire),
    .ack_idx_i  (sel_idx),
    .eoi_i      (eoi_fire && eoi_hit),
    .eoi_idx_i  (eoi_idx),
    .lr_o       (lr)
  );

  vcpu_pend_sel #(.NUM_LR(NUM_LR)) u_sel (
    .lr_i      (lr),
    .elig_o    (elig),
    .hw_pend_o (hw_pend),
    .grant_o   (grant),
    .idx_o     (sel_idx),
    .found_o   (sel_found)
  );

  vcpu_eoi_match #(.NUM_LR(NUM_LR)) u_eoi (
    .lr_i  (lr),
    .vid_i (wdata_i[9:0]),
    .cpu_i (wdata_i[12:10]),
    .hit_o (eoi_hit),
    .idx_o (eoi_idx)
  );

  assign sel_lr = lr[sel_idx];

  vcpu_reg_if #(.AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .sel_found_i (sel_found),
    .sel_lr_i    (sel_lr),
    .ack_fire_o  (ack_fire),
    .eoi_fire_o  (eoi_fire),
    .ctl_en_o    (ctl_en),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o)
  );

  assign any_pend   = |elig;
  assign lr_rdata_o = lr[lr_ridx_i];

  // Raise needs enable; hold drops only when nothing is pending.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      virq_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      virq_o <= virq_o ? any_pend : (any_pend && ctl_en);
      err_o  <= hw_pend;
    end
  end

endmodule

// File: rtl/vcpu_irq_if_chk.sv
module vcpu_irq_if_chk #(
  parameter int unsigned NUM_LR = 4,
  parameter int unsigned AW     = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic              rvalid_o,
  input logic [31:0]       rdata_o,
  input logic              virq_o,
  input logic              any_pend,
  input logic              ctl_en,
  input logic [NUM_LR-1:0] grant
);

  // R1
  rd_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  // R1
  no_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  // R2
  ack_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == AW'('h00C)) |=> (rdata_o[31:13] == '0));

  // R8
  unk_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i != AW'('h000) && addr_i != AW'('h004) &&
     addr_i != AW'('h00C)) |=> (rdata_o == '0));

  // R5
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  // R6
  virq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!virq_o && any_pend && ctl_en) |=> virq_o);

  // R6
  virq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!virq_o && !(any_pend && ctl_en)) |=> !virq_o);

  // R6
  virq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (virq_o && !any_pend) |=> !virq_o);

endmodule

bind vcpu_irq_if vcpu_irq_if_chk #(.NUM_LR(NUM_LR), .AW(AW)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rvalid_o (rvalid_o),
  .rdata_o  (rdata_o),
  .virq_o   (virq_o),
  .any_pend (any_pend),
  .ctl_en   (ctl_en),
  .grant    (grant)
);

// File: tb/vcpu_irq_if_tb_top.sv
module vcpu_irq_if_tb_top;

  localparam int NUM_LR = 4;
  localparam int AW     = 12;
  localparam int IW     = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic          rvalid_o;
  logic [31:0]   rdata_o;
  logic          lr_we_i = 1'b0;
  logic [IW-1:0] lr_idx_i = '0, lr_ridx_i = '0;
  logic [31:0]   lr_wdata_i = '0;
  logic [31:0]   lr_rdata_o;
  logic          virq_o, err_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk_i = ~clk_i;

  vcpu_irq_if #(.NUM_LR(NUM_LR), .AW(AW)) dut_i (.*);

  function automatic logic [31:0] mk_lr(int vid, int cpu, int prio, int st, int hw);
    return {hw[0], 1'b0, st[1:0], prio[4:0], 10'b0, cpu[2:0], vid[9:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as responses appear.
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected rvalid", 32'd1, 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, rdata_o, e);
      end
    end
  end

  task automatic bus_wr(int addr, logic [31:0] data);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = AW'(addr); wdata_i = data;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(int addr, logic [31:0] exp, string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = AW'(addr);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic hv_wr(int idx, logic [31:0] data);
    @(negedge clk_i);
    lr_we_i = 1'b1; lr_idx_i = IW'(idx); lr_wdata_i = data;
    @(negedge clk_i);
    lr_we_i = 1'b0;
  endtask

  task automatic chk_lr(int idx, logic [31:0] exp, string tag);
    lr_ridx_i = IW'(idx);
    #1;
    check(tag, lr_rdata_o, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // Reset state
    check("R6 reset virq", {31'b0, virq_o}, 32'd0);
    check("R9 reset err", {31'b0, err_o}, 32'd0);
    chk_lr(0, 32'd0, "R10 reset entry");
    bus_rd('h000, 32'd0, "R7 reset ctl");

    // Disabled: spurious, no state change, no virq
    hv_wr(0, mk_lr(33, 2, 10, 1, 0));
    chk_lr(0, mk_lr(33, 2, 10, 1, 0), "R10 hv write");
    bus_rd('h00C, 32'd1023, "R3 ack while disabled");
    chk_lr(0, mk_lr(33, 2, 10, 1, 0), "R3 no state change");
    settle();
    check("R6 no virq when disabled", {31'b0, virq_o}, 32'd0);

    bus_wr('h000, 32'h0000_0001);
    settle();
    check("R6 virq rises", {31'b0, virq_o}, 32'd1);

    // Priority and tie order
    hv_wr(1, mk_lr(44, 1, 4, 1, 0));
    hv_wr(2, mk_lr(55, 0, 4, 1, 0));
    bus_rd('h00C, 44 | (1 << 10), "R5 lowest prio, tie to low index");
    chk_lr(1, mk_lr(44, 1, 4, 2, 0), "R2 state to active");
    bus_rd('h00C, 55, "R5 tie second");
    bus_rd('h00C, 33 | (2 << 10), "R2 cpu tag in ack");
    bus_rd('h00C, 32'd1023, "R3 nothing pending");
    settle();
    check("R6 virq falls", {31'b0, virq_o}, 32'd0);

    // End of interrupt
    bus_wr('h010, {19'b0, 3'd2, 10'd44});
    chk_lr(1, mk_lr(44, 1, 4, 2, 0), "R4 mismatch ignored");
    bus_wr('h010, {19'b0, 3'd1, 10'd44});
    chk_lr(1, mk_lr(44, 1, 4, 0, 0), "R4 matched entry invalid");

    // Mask, unknown offsets
    bus_wr('h004, 32'hFFFF_FF1F);
    bus_rd('h004, 32'h0000_001F, "R7 mask readback");
    bus_wr('h008, 32'hDEAD_BEEF);
    bus_rd('h000, 32'h0000_0001, "R8 write to unknown ignored");
    bus_rd('h008, 32'd0, "R8 unknown reads zero");
    bus_rd('h010, 32'd0, "R8 eoi reads zero");

    // Hardware-linked entry
    hv_wr(3, mk_lr(7, 0, 0, 1, 1));
    settle();
    check("R9 err raised", {31'b0, err_o}, 32'd1);
    check("R9 hw entry gives no virq", {31'b0, virq_o}, 32'd0);
    hv_wr(0, mk_lr(33, 2, 20, 1, 0));
    bus_rd('h00C, 33 | (2 << 10), "R9 hw entry skipped");
    bus_rd('h00C, 32'd1023, "R9 hw entry not acked");
    chk_lr(3, mk_lr(7, 0, 0, 1, 1), "R9 hw entry untouched");
    hv_wr(3, 32'd0);
    settle();
    check("R9 err clears", {31'b0, err_o}, 32'd0);

    // Pending-and-active
    hv_wr(1, mk_lr(90, 5, 1, 3, 0));
    bus_rd('h00C, 90 | (5 << 10), "R2 pend-active acked");
    chk_lr(1, mk_lr(90, 5, 1, 2, 0), "R2 pend-active to active");

    // Hold after enable cleared
    hv_wr(2, mk_lr(12, 0, 9, 1, 0));
    settle();
    check("R6 virq up again", {31'b0, virq_o}, 32'd1);
    bus_wr('h000, 32'd0);
    settle();
    check("R6 virq held with enable clear", {31'b0, virq_o}, 32'd1);
    bus_rd('h00C, 32'd1023, "R3 ack with enable clear");
    chk_lr(2, mk_lr(12, 0, 9, 1, 0), "R3 entry still pending");

    settle();
    check("R1 all responses seen", exp_q.size(), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule